// File: doc/BRIEF.md
# Flash Operation Status Generator

This block forms the status byte that a host reads from a flash-style memory while an embedded program or erase is running, or while an erase is on hold. It takes the sequencer's activity flags (busy, erase, program, suspend), the byte being programmed, a per-sector erase-selection mask, a timing-limit flag, the read address and a read strobe. From them it builds a byte of polling, toggle and error bits, and raises a select line that tells the read path to return this byte instead of array contents.

Two toggle bits are kept. The operation toggle flips on each new read while an operation runs. The sector toggle flips only when the read address lands in a sector marked for erase. Sector identity comes from the top address bits. During a suspended erase, reads in unmarked sectors go to the array, while reads in marked sectors still return status. A timing-limit failure latches an error bit that holds status on the bus until the command layer reports a reset command.

Top module: `flash_status_gen`

## Requirements
- R1: `sel_status_o` is 1 when `busy_i` is 1, when the error bit (bit 5) is set, or when `susp_i` is 1 and the addressed sector's mask bit is 1. It is 0 otherwise, which hands the read to array data.
- R2: Bit 7 of `status_o` is the inverse of `prog_data_i[7]` while `prog_i` is 1. Otherwise it is 1 when `susp_i` is 1 and `busy_i` is 0, and 0 in every other case, including a running erase.
- R3: Bit 6 inverts once, at the clock edge that first samples `rd_stb_i` high after it was low, if `busy_i` is 1 or bit 5 is set at that edge. It holds at every other edge. A strobe held high gives one flip only, and a suspend with no program running does not toggle it.
- R4: Bit 2 inverts at a strobe rise when the addressed sector's mask bit is 1 and either `busy_i` and `erase_i` are both 1 or `susp_i` is 1. It holds at every other edge.
- R5: Bit 5 is set at the edge after `tmo_i` and `busy_i` are both 1. It then stays set, even when `busy_i` falls, until an edge that samples `fail_clr_i` high clears it. The clear wins over a set in the same cycle.
- R6: Bit 3 equals `erase_i` OR `susp_i`. It shows that the sector-erase acceptance window has closed.
- R7: Bits 4, 1 and 0 of `status_o` always read 0.
- R8: After reset, bits 6, 5 and 2 are 0, and `sel_status_o` is 0 while the flags are low.
- R9: The sector index is `rd_addr_i[18:16]`, and `sect_mask_i[k]` marks sector k. Lower address bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_i | input | 1 | An embedded program or erase is running |
| erase_i | input | 1 | The current or suspended operation is an erase |
| prog_i | input | 1 | The running operation is a program |
| susp_i | input | 1 | Erase is on hold |
| prog_data_i | input | 8 | Byte being programmed |
| sect_mask_i | input | 8 | Sectors selected for erase |
| tmo_i | input | 1 | Internal timing limit exceeded |
| fail_clr_i | input | 1 | Reset command seen; clears the error bit |
| rd_addr_i | input | 19 | Read address |
| rd_stb_i | input | 1 | Read strobe, high for the duration of a read |
| status_o | output | 8 | Status byte |
| sel_status_o | output | 1 | Return status instead of array data |

## Verification
A read-strobe rise can land in the same clock as a change to the error bit. When the timing limit fires in that clock, bit 6 must use the error state from before the edge. When a clear arrives together with a new timing-limit pulse, the clear must win. The bench places a read rise on exactly those clocks and drops `busy_i` right after the error latches. A behavioural model then predicts every status field, and the design is compared against it on every clock, field by field.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
   localparam int STAT_W   = 8;
   localparam int B_POLL   = 7;
   localparam int B_OPTOG  = 6;
   localparam int B_FAIL   = 5;
   localparam int B_WIN    = 3;
   localparam int B_SECTOG = 2;
   localparam int N_TOG    = 2;
   localparam int T_OP     = 0;
   localparam int T_SECT   = 1;
   typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/fsg_sect_dec.sv
module fsg_sect_dec #(
   parameter int ADDR_W = 19,
   parameter int SECT_W = 3,
   localparam int N_SECT = 1 << SECT_W
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [N_SECT-1:0] mask_i,
   output logic              hit_o
);
   logic [SECT_W-1:0] idx;
   logic              unused_low;

   assign idx        = addr_i[ADDR_W-1 -: SECT_W];
   assign unused_low = ^addr_i[ADDR_W-SECT_W-1:0];
   assign hit_o      = mask_i[idx];
endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         stb_i,
   input  logic [N-1:0] en_i,
   output logic [N-1:0] tog_o
);
   logic stb_q;
   logic rise;

   assign rise = stb_i & ~stb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_q <= 1'b0;
      else        stb_q <= stb_i;
   end

   for (genvar g = 0; g < N; g++) begin : g_tog
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                tog_o[g] <= 1'b0;
         else if (rise && en_i[g])  tog_o[g] <= ~tog_o[g];
      end
   end
endmodule

// File: rtl/fsg_fail.sv
module fsg_fail #(
   parameter bit STICKY = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic fail_o
);
   logic nxt;

   if (STICKY) begin : g_sticky
      assign nxt = ~clr_i & (fail_o | set_i);
   end else begin : g_follow
      assign nxt = ~clr_i & set_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fail_o <= 1'b0;
      else        fail_o <= nxt;
   end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
   import fsg_pkg::*;
#(
   parameter int ADDR_W      = 19,
   parameter int SECT_W      = 3,
   parameter bit FAIL_STICKY = 1'b1,
   localparam int N_SECT     = 1 << SECT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy_i,
   input  logic              erase_i,
   input  logic              prog_i,
   input  logic              susp_i,
   input  logic [7:0]        prog_data_i,
   input  logic [N_SECT-1:0] sect_mask_i,
   input  logic              tmo_i,
   input  logic              fail_clr_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   input  logic              rd_stb_i,
   output logic [7:0]        status_o,
   output logic              sel_status_o
);
   if (SECT_W < 1 || SECT_W >= ADDR_W) begin : g_bad_sect
      $error("SECT_W must lie between 1 and ADDR_W-1");
   end
   if (STAT_W != 8) begin : g_bad_stat
      $error("status byte must be 8 bits");
   end

   logic             in_sect;
   logic             fail_q;
   logic [N_TOG-1:0] tog_en;
   logic [N_TOG-1:0] tog_q;
   logic             poll;
   logic             unused_data;
   stat_t            st;

   fsg_sect_dec #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_dec (
      .addr_i (rd_addr_i),
      .mask_i (sect_mask_i),
      .hit_o  (in_sect)
   );

   fsg_fail #(.STICKY(FAIL_STICKY)) u_fail (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (tmo_i & busy_i),
      .clr_i  (fail_clr_i),
      .fail_o (fail_q)
   );

   assign tog_en[T_OP]   = busy_i | fail_q;
   assign tog_en[T_SECT] = in_sect & ((busy_i & erase_i) | susp_i);

   fsg_toggle #(.N(N_TOG)) u_tog (
      .clk   (clk),
      .rst_n (rst_n),
      .stb_i (rd_stb_i),
      .en_i  (tog_en),
      .tog_o (tog_q)
   );

   assign unused_data = ^prog_data_i[6:0];

   always_comb begin
      if (prog_i)                poll = ~prog_data_i[7];
      else if (susp_i && !busy_i) poll = 1'b1;
      else                       poll = 1'b0;
   end

   always_comb begin
      st           = '0;
      st[B_POLL]   = poll;
      st[B_OPTOG]  = tog_q[T_OP];
      st[B_FAIL]   = fail_q;
      st[B_WIN]    = erase_i | susp_i;
      st[B_SECTOG] = tog_q[T_SECT];
   end

   assign status_o     = st;
   assign sel_status_o = busy_i | fail_q | (susp_i & in_sect);
endmodule

// File: rtl/fsg_chk.sv
module fsg_chk #(
   parameter bit FAIL_STICKY = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       busy_i,
   input logic       erase_i,
   input logic       prog_i,
   input logic       susp_i,
   input logic [7:0] prog_data_i,
   input logic       fail_clr_i,
   input logic       rd_stb_i,
   input logic [7:0] status_o,
   input logic       sel_status_o
);
   logic stb_seen;
   logic rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_seen <= 1'b0;
      else        stb_seen <= rd_stb_i;
   end
   assign rise = rd_stb_i & ~stb_seen;

   // R1
   busy_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |-> sel_status_o);

   // R2
   poll_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_i |-> (status_o[7] == !prog_data_i[7]));

   // R3
   optog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rise |=> $stable(status_o[6]));

   // R3
   optog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && (busy_i || status_o[5])) |=> (status_o[6] != $past(status_o[6])));

   // R4
   secttog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rise |=> $stable(status_o[2]));

   // R5
   fail_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail_clr_i |=> !status_o[5]);

   if (FAIL_STICKY) begin : g_sticky_chk
      // R5
      fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (status_o[5] && !fail_clr_i) |=> status_o[5]);
   end

   // R6
   win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[3] == (erase_i || susp_i));
endmodule

bind flash_status_gen fsg_chk #(.FAIL_STICKY(FAIL_STICKY)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy_i       (busy_i),
   .erase_i      (erase_i),
   .prog_i       (prog_i),
   .susp_i       (susp_i),
   .prog_data_i  (prog_data_i),
   .fail_clr_i   (fail_clr_i),
   .rd_stb_i     (rd_stb_i),
   .status_o     (status_o),
   .sel_status_o (sel_status_o)
);

// File: tb/sim_flash_status_gen.sv
module sim_flash_status_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        busy = 0, erase = 0, prog = 0, susp = 0, tmo = 0, clr = 0, stb = 0;
   logic [7:0]  pdata = '0;
   logic [7:0]  mask = '0;
   logic [18:0] addr = '0;
   logic [7:0]  status;
   logic        sel;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit done = 0;

   // behavioural reference state
   bit m_stb, m_t6, m_t2, m_fail;

   always #4 clk = ~clk;

   flash_status_gen u0 (
      .clk(clk), .rst_n(rst_n), .busy_i(busy), .erase_i(erase), .prog_i(prog),
      .susp_i(susp), .prog_data_i(pdata), .sect_mask_i(mask), .tmo_i(tmo),
      .fail_clr_i(clr), .rd_addr_i(addr), .rd_stb_i(stb),
      .status_o(status), .sel_status_o(sel));

   function automatic bit hit_now();
      int s = int'(addr) / 65536;   // R9: 64 KB sectors from the top bits
      return mask[s];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_stb <= 0; m_t6 <= 0; m_t2 <= 0; m_fail <= 0;
      end else begin
         if (stb && !m_stb) begin
            if (busy || m_fail) m_t6 <= !m_t6;
            if (hit_now() && ((busy && erase) || susp)) m_t2 <= !m_t2;
         end
         m_stb <= stb;
         if (clr) m_fail <= 0;
         else if (tmo && busy) m_fail <= 1;
      end
   end

   task automatic chk(string req, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d at cycle %0d", req, got, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (rst_n && !done) begin
         chk("R1", sel, busy || m_fail || (susp && hit_now()));
         chk("R2", status[7], prog ? !pdata[7] : ((susp && !busy) ? 1 : 0));
         chk("R3", status[6], m_t6);
         chk("R4", status[2], m_t2);
         chk("R5", status[5], m_fail);
         chk("R6", status[3], erase || susp);
         chk("R7", {status[4], status[1:0]}, 0);
      end
      if (cycles > 20000 && !done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got hung expected finish");
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic rd(logic [18:0] a, int hold);
      addr = a; stb = 1; step(hold);
      stb = 0; step(2);
   endtask

   initial begin
      step(3);
      rst_n = 1;
      step(1);
      // R8: reset state
      chk("R8", {status[6], status[5], status[2]}, 0);
      chk("R8", sel, 0);
      rd(19'h1_2345, 2);
      // R2 R3: program with bit7 set, then clear
      busy = 1; prog = 1; pdata = 8'h80; step(1);
      repeat (3) rd(19'h0_0010, 2);
      pdata = 8'h05; rd(19'h7_ffff, 1);
      rd(19'h3_0000, 5);  // held strobe: one flip
      busy = 0; prog = 0; step(2);
      // R4 R9: erase sectors 2 and 5
      mask = 8'b0010_0100; busy = 1; erase = 1; step(1);
      rd(19'h2_0000, 2); rd(19'h2_ffff, 2); rd(19'h5_1234, 2);
      rd(19'h3_0000, 2); rd(19'h4_ffff, 2); rd(19'h6_0000, 2);
      // suspend: marked sectors give status, others array
      busy = 0; susp = 1; step(1);
      rd(19'h2_0100, 2); rd(19'h5_0000, 2); rd(19'h1_0000, 2); rd(19'h7_0000, 2);
      // program inside suspend
      busy = 1; prog = 1; pdata = 8'h7f; step(1);
      rd(19'h1_0000, 2); rd(19'h2_0000, 2);
      busy = 0; prog = 0; step(1);
      rd(19'h5_0000, 2);
      susp = 0; step(1);
      rd(19'h5_0000, 2);
      erase = 0; mask = '0; step(2);
      // R5: timeout during program, read rise in same cycle
      busy = 1; prog = 1; pdata = 8'h00; addr = 19'h0_0000; step(1);
      tmo = 1; stb = 1; step(1);
      tmo = 0; stb = 0; busy = 0; step(2);
      rd(19'h0_1000, 2); rd(19'h6_0000, 2);
      prog = 0; step(1);
      rd(19'h0_0000, 2);
      // clear and set in same cycle: clear wins
      busy = 1; tmo = 1; clr = 1; stb = 1; step(1);
      clr = 0; stb = 0; step(1);
      tmo = 0; busy = 0; step(2);
      rd(19'h0_0000, 2);
      clr = 1; stb = 1; step(1);
      clr = 0; stb = 0; step(2);
      rd(19'h0_0000, 2);
      // reset in mid-operation
      busy = 1; erase = 1; mask = 8'hff; rd(19'h0_0000, 2);
      rst_n = 0; busy = 0; erase = 0; step(2);
      rst_n = 1; step(1);
      chk("R8", {status[6], status[5], status[2]}, 0);
      step(2);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule